// File: doc/BRIEF.md
# Memory Range XOR Checker

This block is a small bus master that confirms a memory image in place, so the image never has to be read back word by word over a slow or unreliable host link. The host supplies a byte start address, an exclusive byte end address, an optional expected value and a compare enable, then pulses a launch strobe. The engine issues one read per word across the range over a request/response memory port. It folds each returned word into a running XOR and, once the range is covered, holds the 32-bit result and a done status until the next launch.

A host checking a large image splits it into fixed chunks, for example 2048 words each. It runs one launch per chunk and reads back a single word, or only the mismatch flag, per chunk. Chunks that fail are rewritten and launched again. The same engine also covers the whole image in one run, before and after the chunk scan.

Top module: `xor_scan_engine`

## Requirements
- R1: When a run finishes, `result_o` equals the XOR of every data word read from byte addresses `start`, `start+4`, ... up to but not including `end`.
- R2: A launch with `start == end` (both aligned) issues no memory read. One cycle after the launch edge, `done_o` is 1, `busy_o` is 0 and `result_o` is 0.
- R3: If `start` or `end` has a nonzero value in its two low bits, or `start > end`, the launch issues no memory read. One cycle later `done_o` and `err_o` are 1 and `result_o` is 0. `err_o` is 0 after any valid run.
- R4: A valid run issues exactly `(end-start)/4` read requests, one at a time. The addresses are word aligned and ascend by 4 from `start`.
- R5: While `rd_req_ready_i` is low, the pending request keeps `rd_req_valid_o` high and its address unchanged. The accumulator changes only when `rd_rsp_valid_i` delivers a word.
- R6: `busy_o` is 1 from the accepted launch edge until the edge on which `done_o` rises, and the two are never high together. A launch while `busy_o` is 1 is ignored and does not alter the range, the reads or the result.
- R7: If the compare enable was 1 at launch and the finished result differs from the expected value latched at launch, `mismatch_o` is 1. Otherwise it is 0, and it is always 0 on an error.
- R8: `done_o`, `result_o`, `err_o` and `mismatch_o` hold their values after a run until the next accepted launch. An accepted launch clears `done_o`.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `mismatch_o` and `rd_req_valid_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Start a run (ignored while busy) |
| start_addr_i | input | ADDR_W | First byte address of the range |
| end_addr_i | input | ADDR_W | Exclusive byte end address |
| cmp_en_i | input | 1 | Enable comparison against expect_i |
| expect_i | input | DATA_W | Expected XOR for the range |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| err_o | output | 1 | Range rejected (misaligned or reversed) |
| mismatch_o | output | 1 | Result differs from expected value |
| result_o | output | DATA_W | XOR of the range |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_addr_o | output | ADDR_W | Read byte address |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | DATA_W | Read data |

## Verification
The bench sweeps every start word from 0 to 8 with lengths of 0 to 6 words, plus a full 64-word range. It repeats the sweep under three memory behaviours: always ready with an immediate response, alternating ready with one cycle of latency, and ready one cycle in three with two cycles of latency. The sweep shows whether the XOR covers the right words, whether the exclusive end is honoured, and whether wait states leak into the result. Misaligned and reversed ranges separate the error path from the empty path, and corrupted expected values separate the compare from the plain result. Launches issued mid-run show that a busy engine keeps its original range.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xs_state_t;
endpackage

// File: rtl/xs_range_check.sv
module xs_range_check #(
  parameter int ADDR_W  = 16,
  parameter int ALIGN_B = 2
) (
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              bad_o,
  output logic              empty_o
);
  logic misaligned;

  generate
    if (ALIGN_B > 0) begin : g_align
      assign misaligned = (|lo_i[ALIGN_B-1:0]) | (|hi_i[ALIGN_B-1:0]);
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign bad_o   = misaligned || (lo_i > hi_i);
  assign empty_o = !bad_o && (lo_i == hi_i);
endmodule

// File: rtl/xs_walker.sv
module xs_walker
  import xs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              bad_i,
  input  logic              empty_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              take_o,
  output logic              finish_o
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  xs_state_t         st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] end_q;
  logic [ADDR_W-1:0] ptr_next;
  logic              last_word;
  logic              quick_end;

  assign ptr_next  = ptr_q + STEP_A;
  assign last_word = (ptr_next == end_q);
  assign accept_o  = launch_i && (st_q == XS_IDLE);
  assign quick_end = accept_o && (bad_i || empty_i);
  assign take_o    = (st_q == XS_WAIT) && rsp_valid_i;
  assign finish_o  = quick_end || (take_o && last_word);

  assign req_valid_o = (st_q == XS_REQ);
  assign req_addr_o  = ptr_q;
  assign busy_o      = (st_q != XS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= XS_IDLE;
      ptr_q <= '0;
      end_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: begin
          if (accept_o && !quick_end) begin
            ptr_q <= lo_i;
            end_q <= hi_i;
            st_q  <= XS_REQ;
          end
        end
        XS_REQ: begin
          if (req_ready_i) st_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (rsp_valid_i) begin
            ptr_q <= ptr_next;
            st_q  <= last_word ? XS_IDLE : XS_REQ;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> ((req_addr_o % STEP) == 0));

  // R4
  req_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_addr_o < end_q));
endmodule

// File: rtl/xs_fold.sv
module xs_fold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] acc_next_o
);
  logic [DATA_W-1:0] acc_q;

  assign acc_next_o = acc_q ^ data_i;
  assign acc_o      = acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) acc_q <= '0;
    else if (take_i)    acc_q <= acc_next_o;
  end
endmodule

// File: rtl/xs_result.sv
module xs_result #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              bad_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic              finish_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              done_o,
  output logic              err_o,
  output logic              mismatch_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] exp_q;
  logic              cmp_q;
  logic [DATA_W-1:0] fin_val;
  logic [DATA_W-1:0] fin_exp;
  logic              fin_cmp;
  logic              fin_bad;

  assign fin_val = take_i   ? value_i  : '0;
  assign fin_exp = accept_i ? expect_i : exp_q;
  assign fin_cmp = accept_i ? cmp_en_i : cmp_q;
  assign fin_bad = accept_i && bad_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      mismatch_o <= 1'b0;
      result_o   <= '0;
      exp_q      <= '0;
      cmp_q      <= 1'b0;
    end else begin
      if (accept_i) begin
        exp_q      <= expect_i;
        cmp_q      <= cmp_en_i;
        done_o     <= 1'b0;
        err_o      <= bad_i;
        mismatch_o <= 1'b0;
        result_o   <= '0;
      end
      if (finish_i) begin
        done_o     <= 1'b1;
        result_o   <= fin_val;
        mismatch_o <= fin_cmp && !fin_bad && (fin_val != fin_exp);
      end
    end
  end

  // R7
  mismatch_done_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |-> done_o);

  // R3
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && result_o == '0 && !mismatch_o));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !accept_i) |=> (done_o && $stable(result_o)));
endmodule

// File: rtl/xor_scan_engine.sv
module xor_scan_engine
  import xs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mismatch_o,
  output logic [DATA_W-1:0] result_o,
  output logic              rd_req_valid_o,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_req_ready_i,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i
);
  localparam int STEP    = DATA_W / 8;
  localparam int ALIGN_B = $clog2(STEP);

  logic              bad;
  logic              empty;
  logic              accept;
  logic              take;
  logic              finish;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] acc_next;

  xs_range_check #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B)) u_range (
    .lo_i(start_addr_i), .hi_i(end_addr_i), .bad_o(bad), .empty_o(empty)
  );

  xs_walker #(.ADDR_W(ADDR_W), .STEP(STEP)) u_walk (
    .clk(clk), .rst(rst), .launch_i(launch_i),
    .lo_i(start_addr_i), .hi_i(end_addr_i), .bad_i(bad), .empty_i(empty),
    .req_ready_i(rd_req_ready_i), .rsp_valid_i(rd_rsp_valid_i),
    .req_valid_o(rd_req_valid_o), .req_addr_o(rd_req_addr_o),
    .busy_o(busy_o), .accept_o(accept), .take_o(take), .finish_o(finish)
  );

  xs_fold #(.DATA_W(DATA_W)) u_fold (
    .clk(clk), .rst(rst), .clear_i(accept), .take_i(take),
    .data_i(rd_rsp_data_i), .acc_o(acc), .acc_next_o(acc_next)
  );

  xs_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .accept_i(accept), .bad_i(bad),
    .cmp_en_i(cmp_en_i), .expect_i(expect_i), .finish_i(finish),
    .take_i(take), .value_i(acc_next),
    .done_o(done_o), .err_o(err_o), .mismatch_o(mismatch_o), .result_o(result_o)
  );

  // R5
  acc_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rd_rsp_valid_i) |=> $stable(acc));

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && launch_i) |=> !done_o || $past(rd_rsp_valid_i));

  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_req_valid_o);
endmodule

// File: tb/sim_xor_scan_engine.sv
module sim_xor_scan_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          launch = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic          cmp_en = 1'b0;
  logic [DW-1:0] expect_v = '0;
  logic          busy, done, err, mismatch;
  logic [DW-1:0] result;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          rd_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int nreads = 0;
  int exp_addr = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_scan_engine #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .launch_i(launch),
    .start_addr_i(start_addr), .end_addr_i(end_addr),
    .cmp_en_i(cmp_en), .expect_i(expect_v),
    .busy_o(busy), .done_o(done), .err_o(err), .mismatch_o(mismatch),
    .result_o(result),
    .rd_req_valid_o(req_valid), .rd_req_addr_o(req_addr),
    .rd_req_ready_i(rd_ready), .rd_rsp_valid_i(rsp_valid),
    .rd_rsp_data_i(rsp_data)
  );

  function automatic logic [31:0] mem_word(input int idx);
    logic [31:0] i;
    i = 32'(idx & 63);
    return (i * 32'h9E3779B1) ^ (i << 17) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Memory model: changes only on falling edges.
  bit            pv = 0;
  bit            pr = 0;
  logic [AW-1:0] paddr = '0;
  bit            pend = 0;
  int            lat_cnt = 0;
  logic [AW-1:0] pend_addr = '0;

  always @(negedge clk) begin
    if (rst) begin
      pv = 0; pr = 0; pend = 0; rd_ready = 1'b0; rsp_valid = 1'b0;
    end else begin
      if (pv && pr) begin
        nreads++;
        chk(int'(paddr) == exp_addr, "R4", "request address", 32'(paddr), 32'(exp_addr));
        exp_addr += 4;
        pend = 1;
        pend_addr = paddr;
        lat_cnt = mode;
      end else if (pv && !pr) begin
        chk(req_valid && req_addr == paddr, "R5", "stalled request held",
            {15'd0, req_valid, req_addr}, {15'd0, 1'b1, paddr});
      end
      rsp_valid = 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem_word(int'(pend_addr) / 4);
          pend = 0;
        end else begin
          lat_cnt--;
        end
      end
      cyc++;
      case (mode)
        0: pr = 1;
        1: pr = cyc[0];
        default: pr = (cyc % 3) == 0;
      endcase
      rd_ready = pr;
      pv = req_valid;
      paddr = req_addr;
    end
  end

  task automatic run(input int s, input int e, input bit cmp, input bit corrupt, input bit poke);
    logic [31:0] x;
    bit bad;
    int words;
    int t;
    logic [31:0] held;
    x = '0;
    bad = (s % 4 != 0) || (e % 4 != 0) || (s > e);
    words = bad ? 0 : (e - s) / 4;
    for (int i = s / 4; i < s / 4 + words; i++) x ^= mem_word(i);
    @(negedge clk);
    start_addr = AW'(s); end_addr = AW'(e); cmp_en = cmp;
    expect_v = corrupt ? (x ^ 32'h1) : x;
    exp_addr = s; nreads = 0; launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    if (words == 0) begin
      if (bad) chk(done && !busy, "R3", "rejected range done at once", {30'd0, done, busy}, 32'h2);
      else     chk(done && !busy, "R2", "empty range done at once", {30'd0, done, busy}, 32'h2);
    end else begin
      chk(busy && !done, "R6", "busy after launch", {30'd0, busy, done}, 32'h2);
      if (poke) begin
        start_addr = AW'(0); end_addr = AW'(8); launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
      end
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(result == (bad ? 32'h0 : x), bad ? "R3" : "R1", "result", result, bad ? 32'h0 : x);
    chk(err == bad, "R3", "error flag", {31'd0, err}, {31'd0, bad});
    chk(mismatch == (cmp && corrupt && !bad), "R7", "mismatch flag",
        {31'd0, mismatch}, {31'd0, cmp && corrupt && !bad});
    chk(nreads == words, "R4", "read count", 32'(nreads), 32'(words));
    chk(!busy, "R6", "busy low with done", {31'd0, busy}, 32'h0);
    held = result;
    repeat (3) @(negedge clk);
    chk(done && result == held, "R8", "done and result held", result, held);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !mismatch && !req_valid && result == 0, "R9", "reset state",
        {27'd0, busy, done, err, mismatch, req_valid}, 32'h0);
    chk(result == 0, "R9", "reset result", result, 32'h0);
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int s = 0; s < 9; s++) begin
        for (int len = 0; len < 7; len++) begin
          run(s * 4, s * 4 + len * 4, ((s + len) % 3) != 0, len[0], (len >= 2) && (s == 1));
        end
      end
      run(0, 256, 1'b1, 1'b0, 1'b1);
      run(2, 16, 1'b1, 1'b0, 1'b0);
      run(4, 18, 1'b1, 1'b1, 1'b0);
      run(20, 8, 1'b1, 1'b0, 1'b0);
      run(8, 8, 1'b1, 1'b1, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule